// File: doc/BRIEF.md
# I2C Slave with Ten-Bit Addressing

This block is an I2C target that answers a single 10-bit bus address. It watches SCL and SDA through a short synchronizer running on the system clock and finds bus START, repeated START and STOP conditions. It then runs the two-byte address phase and drives acknowledge bits onto SDA through an open-drain enable. Data bytes pass through a one-byte receive register and a one-byte transmit holding register.

When the master writes, the first byte carries the fixed ten-bit prefix, the two upper address bits and a cleared direction bit. The second byte carries the lower eight address bits. Received data bytes then follow, and the block acknowledges each one. To read, the master first performs this full write-style addressing. It then issues a repeated START and resends only the first byte with the direction bit set. The block remembers the completed 10-bit match across the repeated START, so that one byte is enough to select transmit mode.

Sticky status flags report an address match, a STOP or repeated START, and a transmit underrun. A level flag reports the current direction. A single interrupt line is the OR of the sticky flags. A one-cycle acknowledge strobe from the host clears all sticky flags.

Top module: `i2c_slave10`

## Requirements
- R1: SCL and SDA are synchronized through two flops. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. SDA moving while SCL is low creates no bus event.
- R2: A first address byte of the form bits 7..3 = 11110, bits 2..1 = own_addr[9:8], bit 0 = 0 (write) is acknowledged: the block drives SDA low during the ninth clock.
- R3: After such a first byte, a second byte equal to own_addr[7:0] is acknowledged. It sets flag_match and irq, and flag_read stays 0.
- R4: A wrong prefix, wrong upper bits or a wrong second byte is not acknowledged. SDA then stays released for the rest of that transfer, and flag_match stays 0.
- R5: In a write, data bits are sampled on rising SCL, MSB first. After the eighth bit, rx_data holds the byte, rx_valid pulses for one cycle, and the byte is acknowledged. The block changes its SDA drive only while SCL is low.
- R6: After a full match, a repeated START and a first byte with matching upper bits and bit 0 = 1 is acknowledged. This sets flag_read to 1, and the loaded transmit byte is then sent MSB first.
- R7: When the master acknowledges (SDA low), the next byte follows. When the master does not acknowledge (SDA high), the block releases SDA and sends nothing more until the next START.
- R8: If no byte has been loaded since the last one was sent, the block sends 0xFF and sets flag_underrun.
- R9: A STOP or a repeated START sets flag_stop and irq.
- R10: A one-cycle pulse on flags_ack clears flag_match, flag_stop and flag_underrun. If an event arrives in the same cycle, the event wins.
- R11: A STOP, or a repeated START that was not preceded by a full 10-bit match, leaves no remembered match. A following read byte is then not acknowledged.
- R12: After reset, sda_oe, all flags and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level from the bus |
| sda_i | input | 1 | SDA level from the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| own_addr | input | 10 | Programmed 10-bit address |
| tx_data | input | 8 | Byte to load for transmit |
| tx_load | input | 1 | Loads tx_data into the holding register |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse on a new received byte |
| flag_match | output | 1 | Sticky full 10-bit address match |
| flag_read | output | 1 | Current transfer is master-read |
| flag_stop | output | 1 | Sticky STOP or repeated START seen |
| flag_underrun | output | 1 | Sticky transmit underrun |
| flags_ack | input | 1 | Clears the sticky flags |
| irq | output | 1 | Interrupt request, OR of the sticky flags |

## Verification
The address phase is exercised with first bytes that differ only in the prefix, only in the upper address bits, or only in the direction bit, and with second bytes one bit off from the programmed value. These cases separate the checks on prefix, upper bits, direction and lower byte. Read re-addressing is tried three ways: after a full match, after a STOP, and after a repeated START that followed a failed second byte. This shows that only a completed match survives into transmit mode. Transmit runs first with a loaded byte and then with none, which separates normal data from the 0xFF underrun fill. A master NAK followed by one extra clock confirms that SDA stays released.

// File: rtl/i2c_slave10_pkg.sv
package i2c_slave10_pkg;

    localparam int ADDR_W = 10;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int PFX_W  = 5;
    localparam logic [PFX_W-1:0] TEN_BIT_PREFIX = 5'b11110;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACKW,
        ST_ACK,
        ST_SEND,
        ST_MACKW,
        ST_MACK,
        ST_SENDW,
        ST_IGNORE
    } state_t;

    typedef enum logic [1:0] {
        K_ADDR1,
        K_ADDR2,
        K_DATA
    } kind_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl_lvl;
        logic sda_lvl;
    } bus_ev_t;

    typedef struct packed {
        logic match;
        logic stop_seen;
        logic underrun;
    } flag_ev_t;

    function automatic logic head_hit(input logic [BYTE_W-1:0] b,
                                      input logic [1:0] hi);
        return (b[BYTE_W-1 -: PFX_W] == TEN_BIT_PREFIX) && (b[2:1] == hi);
    endfunction

endpackage

// File: rtl/i2c_slave10_sync.sv
module i2c_slave10_sync
    import i2c_slave10_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_sr, sda_sr;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    always_comb begin
        scl_s       = scl_sr[STAGES-1];
        sda_s       = sda_sr[STAGES-1];
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.scl_lvl  = scl_s;
        ev.sda_lvl  = sda_s;
    end

endmodule

// File: rtl/i2c_slave10_ctrl.sv
module i2c_slave10_ctrl
    import i2c_slave10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              xmit,
    output flag_ev_t          fev
);

    state_t             state;
    kind_t              kind;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  shreg, tx_buf, nb, tx_next;
    logic               tx_valid, matched, busy, do_ack;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    always_comb begin
        nb      = {shreg[BYTE_W-2:0], ev.sda_lvl};
        tx_next = tx_valid ? tx_buf : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind     <= K_ADDR1;
            cnt      <= '0;
            shreg    <= '0;
            tx_buf   <= '0;
            tx_valid <= 1'b0;
            matched  <= 1'b0;
            busy     <= 1'b0;
            do_ack   <= 1'b0;
            xmit     <= 1'b0;
            sda_oe   <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            fev      <= '0;
        end else begin
            rx_valid <= 1'b0;
            fev      <= '0;
            if (ev.stop) begin
                state         <= ST_IDLE;
                sda_oe        <= 1'b0;
                matched       <= 1'b0;
                busy          <= 1'b0;
                xmit          <= 1'b0;
                fev.stop_seen <= 1'b1;
            end else if (ev.start) begin
                if (busy) fev.stop_seen <= 1'b1;
                busy   <= 1'b1;
                state  <= ST_RECV;
                kind   <= K_ADDR1;
                cnt    <= '0;
                sda_oe <= 1'b0;
                xmit   <= 1'b0;
            end else begin
                unique case (state)
                    ST_RECV: if (ev.scl_rise) begin
                        shreg <= nb;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            state <= ST_ACKW;
                            unique case (kind)
                                K_ADDR1: begin
                                    if (head_hit(nb, own_addr[ADDR_W-1 -: 2])) begin
                                        if (!nb[0]) begin
                                            do_ack  <= 1'b1;
                                            kind    <= K_ADDR2;
                                            matched <= 1'b0;
                                        end else if (matched) begin
                                            do_ack <= 1'b1;
                                            xmit   <= 1'b1;
                                        end else begin
                                            do_ack <= 1'b0;
                                        end
                                    end else begin
                                        do_ack  <= 1'b0;
                                        matched <= 1'b0;
                                    end
                                end
                                K_ADDR2: begin
                                    if (nb == own_addr[BYTE_W-1:0]) begin
                                        do_ack    <= 1'b1;
                                        matched   <= 1'b1;
                                        fev.match <= 1'b1;
                                        kind      <= K_DATA;
                                    end else begin
                                        do_ack <= 1'b0;
                                    end
                                end
                                default: begin
                                    do_ack   <= 1'b1;
                                    rx_data  <= nb;
                                    rx_valid <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACKW: if (ev.scl_fall) begin
                        if (do_ack) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                        end else begin
                            state  <= ST_IGNORE;
                        end
                    end
                    ST_ACK, ST_SENDW: if (ev.scl_fall) begin
                        if (xmit) begin
                            shreg        <= tx_next;
                            sda_oe       <= ~tx_next[BYTE_W-1];
                            fev.underrun <= ~tx_valid;
                            tx_valid     <= 1'b0;
                            cnt          <= '0;
                            state        <= ST_SEND;
                        end else begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_RECV;
                        end
                    end
                    ST_SEND: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) state <= ST_MACKW;
                        end else if (ev.scl_fall) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_MACKW: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                    end
                    ST_MACK: if (ev.scl_rise) begin
                        state <= ev.sda_lvl ? ST_IGNORE : ST_SENDW;
                    end
                    default: ;
                endcase
            end
            if (tx_load) begin
                tx_buf   <= tx_data;
                tx_valid <= 1'b1;
            end
        end
    end

    assert_sda_moves_low_scl_R5: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !ev.scl_lvl);

    assert_stop_forgets_match_R11: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !matched);

    assert_read_needs_match_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(xmit) |-> $past(matched));

endmodule

// File: rtl/i2c_slave10_flags.sv
module i2c_slave10_flags
    import i2c_slave10_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  flag_ev_t fev,
    input  logic     clr,
    output logic     flag_match,
    output logic     flag_stop,
    output logic     flag_underrun,
    output logic     irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_match    <= 1'b0;
            flag_stop     <= 1'b0;
            flag_underrun <= 1'b0;
        end else begin
            if (clr) begin
                flag_match    <= 1'b0;
                flag_stop     <= 1'b0;
                flag_underrun <= 1'b0;
            end
            if (fev.match)     flag_match    <= 1'b1;
            if (fev.stop_seen) flag_stop     <= 1'b1;
            if (fev.underrun)  flag_underrun <= 1'b1;
        end
    end

    assign irq = flag_match | flag_stop | flag_underrun;

    assert_match_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
        fev.match |=> flag_match);

    assert_stop_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
        fev.stop_seen |=> flag_stop);

    assert_ack_clears_match_R10: assert property (@(posedge clk) disable iff (rst)
        (clr && !fev.match) |=> !flag_match);

endmodule

// File: rtl/i2c_slave10.sv
module i2c_slave10
    import i2c_slave10_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              flag_match,
    output logic              flag_read,
    output logic              flag_stop,
    output logic              flag_underrun,
    input  logic              flags_ack,
    output logic              irq
);

    bus_ev_t  ev;
    flag_ev_t fev;

    i2c_slave10_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_slave10_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .own_addr (own_addr),
        .tx_data  (tx_data),
        .tx_load  (tx_load),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .xmit     (flag_read),
        .fev      (fev)
    );

    i2c_slave10_flags flags_i (
        .clk           (clk),
        .rst           (rst),
        .fev           (fev),
        .clr           (flags_ack),
        .flag_match    (flag_match),
        .flag_stop     (flag_stop),
        .flag_underrun (flag_underrun),
        .irq           (irq)
    );

    assert_no_drive_in_reset_R12: assert property (@(posedge clk)
        rst |=> !sda_oe);

endmodule

// File: tb/i2c_slave10_tb.sv
module i2c_slave10_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam logic [9:0] OWN = 10'h2A5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       sda_oe, sda_bus;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, flag_match, flag_read, flag_stop, flag_underrun, irq;
    logic       flags_ack = 1'b0;

    int n_chk = 0, n_fail = 0, rx_cnt = 0, oe_viol = 0;
    logic [7:0] last_rx = '0;
    logic       prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_slave10 dut_i (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .own_addr(OWN), .tx_data(tx_data), .tx_load(tx_load),
        .rx_data(rx_data), .rx_valid(rx_valid), .flag_match(flag_match),
        .flag_read(flag_read), .flag_stop(flag_stop), .flag_underrun(flag_underrun),
        .flags_ack(flags_ack), .irq(irq)
    );

    always @(posedge clk) begin
        prev_oe <= sda_oe;
        if (!rst && rx_valid) begin
            last_rx <= rx_data;
            rx_cnt  <= rx_cnt + 1;
        end
        if (!rst && m_scl && sda_oe !== prev_oe) oe_viol <= oe_viol + 1;
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic v, output logic s);
        m_sda = v; wq();
        m_scl = 1'b1; wq();
        s = sda_bus; wq();
        m_scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic get_byte(input logic nak, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(nak, s);
    endtask

    task automatic clear_flags();
        @(negedge clk); flags_ack = 1'b1; @(negedge clk); flags_ack = 1'b0; wq();
    endtask

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 sda_oe after reset", sda_oe, 0);
        chk("R12 flags after reset", {flag_match, flag_read, flag_stop, flag_underrun}, 0);
        chk("R12 irq after reset", irq, 0);
    endtask

    task automatic t_write();
        logic a;
        int  c0;
        c0 = rx_cnt;
        bus_start();
        put_byte(8'hF4, a); chk("R2 first byte ack", a, 1);
        put_byte(8'hA5, a); chk("R3 second byte ack", a, 1);
        chk("R3 match flag", flag_match, 1);
        chk("R3 irq", irq, 1);
        chk("R3 read flag low", flag_read, 0);
        put_byte(8'h3C, a); chk("R5 data ack", a, 1);
        chk("R5 rx byte", last_rx, 8'h3C);
        put_byte(8'hC3, a);
        chk("R5 rx byte 2", last_rx, 8'hC3);
        chk("R5 rx count", rx_cnt - c0, 2);
        bus_stop(); wq();
        chk("R9 stop flag", flag_stop, 1);
        clear_flags();
        chk("R10 flags cleared", {flag_match, flag_stop, flag_underrun}, 0);
        chk("R10 irq cleared", irq, 0);
    endtask

    task automatic t_noise();
        m_scl = 1'b0; wq(); m_sda = 1'b0; wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); wq();
        chk("R1 no event from SDA with SCL low", {flag_stop, flag_match}, 0);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] b;
        logic s;
        load_tx(8'h96);
        bus_start();
        put_byte(8'hF4, a);
        put_byte(8'hA5, a);
        clear_flags();
        bus_start();
        chk("R9 restart flag", flag_stop, 1);
        chk("R1 restart detected", irq, 1);
        put_byte(8'hF5, a); chk("R6 read byte ack", a, 1);
        chk("R6 read flag", flag_read, 1);
        get_byte(1'b0, b);
        chk("R6 first tx byte", b, 8'h96);
        chk("R8 no underrun yet", flag_underrun, 0);
        get_byte(1'b1, b);
        chk("R8 underrun fill", b, 8'hFF);
        chk("R8 underrun flag", flag_underrun, 1);
        clk_bit(1'b1, s);
        chk("R7 released after NAK", s, 1);
        chk("R7 sda_oe after NAK", sda_oe, 0);
        bus_stop(); wq();
        clear_flags();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        put_byte(8'hF2, a); chk("R4 wrong upper bits", a, 0);
        put_byte(8'h55, a); chk("R4 stays released", a, 0);
        bus_stop();
        bus_start();
        put_byte(8'hE4, a); chk("R4 wrong prefix", a, 0);
        bus_stop();
        bus_start();
        put_byte(8'hF4, a); chk("R2 first byte ack again", a, 1);
        put_byte(8'hA4, a); chk("R4 wrong low byte", a, 0);
        bus_stop(); wq();
        chk("R4 no match flag", flag_match, 0);
        clear_flags();
    endtask

    task automatic t_forget();
        logic a;
        bus_start();
        put_byte(8'hF4, a);
        put_byte(8'hA5, a);
        bus_stop();
        bus_start();
        put_byte(8'hF5, a); chk("R11 read after STOP ignored", a, 0);
        bus_stop();
        bus_start();
        put_byte(8'hF4, a);
        put_byte(8'hA4, a);
        bus_start();
        put_byte(8'hF5, a); chk("R11 read after failed match ignored", a, 0);
        chk("R11 read flag low", flag_read, 0);
        bus_stop(); wq();
        clear_flags();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_noise();
        t_read();
        t_mismatch();
        t_forget();
        chk("R5 SDA drive changed only with SCL low", oe_viol, 0);
        finish_run();
    end

endmodule